// File: doc/BRIEF.md
# Auto-Incrementing Work-RAM Data Port

This block gives a host a byte-wide window into a 128 KiB work RAM without a wide address bus. The host first loads a 17-bit pointer through three byte-sized pointer registers: low byte, middle byte, and a top register that carries only bit 16. It then moves data through a single data register. Each read or write of the data register becomes one memory access at the pointer, and the pointer then advances by one. A run of consecutive data accesses therefore walks through memory with no further address writes.

The memory side is a plain request port. It presents a 24-bit address, separate read and write strobes, and write data. The memory must return read data in the same cycle as the read strobe. Every access lands in a fixed high bank: the pointer is OR'd onto a 24-bit bank base. The block registers the returned byte and presents it to the host one cycle later, together with a one-cycle valid pulse.

Top module: `wram_port`

## Requirements
- R1: After reset the pointer is zero, so `mem_addr_o` reads 0x7E0000. `reg_rvalid_o` and `reg_rdata_o` are 0, and both memory strobes are low.
- R2: A host write to offset 0x2181 replaces pointer bits 7..0 with the written byte and leaves the other pointer bits unchanged.
- R3: A host write to offset 0x2182 replaces pointer bits 15..8 with the written byte and leaves the other pointer bits unchanged.
- R4: A host write to offset 0x2183 sets pointer bit 16 from data bit 0. Data bits 7..1 of that write have no effect on the pointer.
- R5: `mem_addr_o` always equals 0x7E0000 OR the 17-bit pointer, so bits 23..17 always read 0x3F.
- R6: A host write to the data register at 0x2180 raises `mem_wr_o` in the same cycle. In that cycle `mem_wdata_o` equals the host byte and the address is the pointer before the increment. From the next cycle the pointer is one higher.
- R7: A host read of 0x2180 raises `mem_rd_o` in the same cycle at the current pointer, and the pointer then increments. In the next cycle `reg_rdata_o` holds the byte that the memory returned and `reg_rvalid_o` is high for exactly that one cycle.
- R8: The pointer increments from 0x1FFFF to 0x00000, and the increment never carries into address bits 23..17.
- R9: Host accesses outside 0x2180..0x2183, and host reads of the three pointer offsets, raise no memory strobe, raise no `reg_rvalid_o`, and leave the pointer unchanged.
- R10: When `reg_wr_i` and `reg_rd_i` are both high on 0x2180, the cycle acts as a data write only. `mem_rd_o` stays low, no `reg_rvalid_o` follows, and the pointer increments once.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| reg_addr_i | input | 16 | Host register address |
| reg_wr_i | input | 1 | Host write enable |
| reg_rd_i | input | 1 | Host read enable |
| reg_wdata_i | input | 8 | Host write data |
| reg_rdata_o | output | 8 | Registered read data |
| reg_rvalid_o | output | 1 | Read data valid, one cycle after a data read |
| mem_addr_o | output | 24 | Memory address: bank base OR pointer |
| mem_wr_o | output | 1 | Memory write strobe |
| mem_rd_o | output | 1 | Memory read strobe |
| mem_wdata_o | output | 8 | Memory write data |
| mem_rdata_i | input | 8 | Memory read data, valid in the cycle of `mem_rd_o` |

## Verification
`mem_addr_o` is a direct view of the pointer, so a wrong pointer shows on that port in the very next cycle. This covers a byte lane loaded into the wrong bits, a dropped or doubled increment, and a carry that leaks into the bank bits. A fault in the read-return register shows one cycle after the read strobe, as a missing or extra valid pulse or a wrong byte. The bench reads back a written sequence and compares against its own model of the memory. It checks the pointer after every vector, so a fault is seen within one access of where it arises.

// File: rtl/wram_port_pkg.sv
package wram_port_pkg;
  localparam int BYTE_W = 8;

  function automatic int lane_count(input int width);
    return (width + BYTE_W - 1) / BYTE_W;
  endfunction

  typedef enum logic [1:0] {
    ACC_NONE = 2'd0,
    ACC_WR   = 2'd1,
    ACC_RD   = 2'd2
  } acc_e;
endpackage

// File: rtl/wram_port_decode.sv
module wram_port_decode
  import wram_port_pkg::*;
#(
  parameter int              HOST_AW   = 16,
  parameter logic [15:0]     BASE_ADDR = 16'h2180,
  parameter int              NLANE     = 3
) (
  input  logic [HOST_AW-1:0] reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  output acc_e               data_acc_o,
  output logic [NLANE-1:0]   lane_we_o
);
  localparam int NREG = NLANE + 1;

  logic [HOST_AW-1:0] off;
  logic               in_win;
  logic [NREG-1:0]    sel;

  assign off    = reg_addr_i - HOST_AW'(BASE_ADDR);
  assign in_win = (reg_addr_i >= HOST_AW'(BASE_ADDR)) && (off < HOST_AW'(NREG));

  for (genvar k = 0; k < NREG; k++) begin : g_sel
    assign sel[k] = in_win && (off == HOST_AW'(k));
  end

  // write wins over read on the data register
  always_comb begin
    data_acc_o = ACC_NONE;
    if (sel[0] && reg_wr_i)      data_acc_o = ACC_WR;
    else if (sel[0] && reg_rd_i) data_acc_o = ACC_RD;
  end

  // pointer registers are write-only
  for (genvar k = 0; k < NLANE; k++) begin : g_lane
    assign lane_we_o[k] = sel[k+1] && reg_wr_i;
  end
endmodule

// File: rtl/wram_port_ptr.sv
module wram_port_ptr
  import wram_port_pkg::*;
#(
  parameter int PTR_W = 17,
  localparam int NLANE = lane_count(PTR_W)
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic [NLANE-1:0]  lane_we_i,
  input  logic [BYTE_W-1:0] wdata_i,
  input  logic              step_i,
  output logic [PTR_W-1:0]  ptr_o
);
  logic [PTR_W-1:0] ptr_q, ptr_d;

  always_comb begin
    ptr_d = ptr_q;
    if (step_i) ptr_d = ptr_q + PTR_W'(1);
    // top lane may be narrower than a byte; extra data bits fall away
    for (int b = 0; b < PTR_W; b++) begin
      if (lane_we_i[b / BYTE_W]) ptr_d[b] = wdata_i[b % BYTE_W];
    end
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) ptr_q <= '0;
    else         ptr_q <= ptr_d;
  end

  assign ptr_o = ptr_q;
endmodule

// File: rtl/wram_port_rdata.sv
module wram_port_rdata
  import wram_port_pkg::*;
(
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              capture_i,
  input  logic [BYTE_W-1:0] mem_rdata_i,
  output logic [BYTE_W-1:0] rdata_o,
  output logic              rvalid_o
);
  logic [BYTE_W-1:0] rdata_q;
  logic              rvalid_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      rdata_q  <= '0;
      rvalid_q <= 1'b0;
    end else begin
      rvalid_q <= capture_i;
      if (capture_i) rdata_q <= mem_rdata_i;
    end
  end

  assign rdata_o  = rdata_q;
  assign rvalid_o = rvalid_q;
endmodule

// File: rtl/wram_port.sv
module wram_port
  import wram_port_pkg::*;
#(
  parameter int          HOST_AW   = 16,
  parameter int          ADDR_W    = 24,
  parameter int          PTR_W     = 17,
  parameter logic [15:0] BASE_ADDR = 16'h2180,
  parameter logic [23:0] BANK_BASE = 24'h7E0000
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [HOST_AW-1:0] reg_addr_i,
  input  logic               reg_wr_i,
  input  logic               reg_rd_i,
  input  logic [BYTE_W-1:0]  reg_wdata_i,
  output logic [BYTE_W-1:0]  reg_rdata_o,
  output logic               reg_rvalid_o,
  output logic [ADDR_W-1:0]  mem_addr_o,
  output logic               mem_wr_o,
  output logic               mem_rd_o,
  output logic [BYTE_W-1:0]  mem_wdata_o,
  input  logic [BYTE_W-1:0]  mem_rdata_i
);
  localparam int NLANE = lane_count(PTR_W);

  acc_e             data_acc;
  logic [NLANE-1:0] lane_we;
  logic [PTR_W-1:0] ptr;
  logic             step;

  wram_port_decode #(
    .HOST_AW  (HOST_AW),
    .BASE_ADDR(BASE_ADDR),
    .NLANE    (NLANE)
  ) u_decode (
    .reg_addr_i(reg_addr_i),
    .reg_wr_i  (reg_wr_i),
    .reg_rd_i  (reg_rd_i),
    .data_acc_o(data_acc),
    .lane_we_o (lane_we)
  );

  assign step = (data_acc != ACC_NONE);

  wram_port_ptr #(
    .PTR_W(PTR_W)
  ) u_ptr (
    .clk_i    (clk_i),
    .rst_ni   (rst_ni),
    .lane_we_i(lane_we),
    .wdata_i  (reg_wdata_i),
    .step_i   (step),
    .ptr_o    (ptr)
  );

  // pointer is OR'd onto the bank base, never added
  assign mem_addr_o  = ADDR_W'(BANK_BASE) | ADDR_W'(ptr);
  assign mem_wr_o    = (data_acc == ACC_WR);
  assign mem_rd_o    = (data_acc == ACC_RD);
  assign mem_wdata_o = reg_wdata_i;

  wram_port_rdata u_rdata (
    .clk_i      (clk_i),
    .rst_ni     (rst_ni),
    .capture_i  (mem_rd_o),
    .mem_rdata_i(mem_rdata_i),
    .rdata_o    (reg_rdata_o),
    .rvalid_o   (reg_rvalid_o)
  );
endmodule

// File: rtl/wram_port_chk.sv
module wram_port_chk #(
  parameter int          HOST_AW   = 16,
  parameter int          ADDR_W    = 24,
  parameter int          PTR_W     = 17,
  parameter logic [15:0] BASE_ADDR = 16'h2180,
  parameter logic [23:0] BANK_BASE = 24'h7E0000
) (
  input logic               clk_i,
  input logic               rst_ni,
  input logic [HOST_AW-1:0] reg_addr_i,
  input logic               reg_wr_i,
  input logic               reg_rd_i,
  input logic [7:0]         reg_rdata_o,
  input logic               reg_rvalid_o,
  input logic [ADDR_W-1:0]  mem_addr_o,
  input logic               mem_wr_o,
  input logic               mem_rd_o,
  input logic [7:0]         mem_rdata_i
);
  localparam logic [ADDR_W-1:0] PMASK    = ADDR_W'((64'd1 << PTR_W) - 64'd1);
  localparam logic [ADDR_W-1:0] BANK_HI  = ADDR_W'(BANK_BASE) & ~PMASK;
  localparam logic [HOST_AW-1:0] WIN_LO  = HOST_AW'(BASE_ADDR);
  localparam logic [HOST_AW-1:0] WIN_HI  = HOST_AW'(BASE_ADDR) + HOST_AW'(3);

  // R6 R7 R8
  step_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_wr_o || mem_rd_o) |=>
      (mem_addr_o[PTR_W-1:0] == PTR_W'($past(mem_addr_o[PTR_W-1:0]) + PTR_W'(1))));

  // R5
  bank_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mem_addr_o & ~PMASK) == BANK_HI);

  // R7
  rdata_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    mem_rd_o |=> (reg_rvalid_o && (reg_rdata_o == $past(mem_rdata_i))));

  // R7
  rvalid_src_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    reg_rvalid_o |-> $past(mem_rd_o));

  // R10
  excl_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(mem_wr_o && mem_rd_o));

  // R9
  idle_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!reg_wr_i && !reg_rd_i) |=> $stable(mem_addr_o));

  // R9
  outside_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((reg_addr_i < WIN_LO) || (reg_addr_i > WIN_HI)) |-> (!mem_wr_o && !mem_rd_o));
endmodule

bind wram_port wram_port_chk #(
  .HOST_AW  (HOST_AW),
  .ADDR_W   (ADDR_W),
  .PTR_W    (PTR_W),
  .BASE_ADDR(BASE_ADDR),
  .BANK_BASE(BANK_BASE)
) u_chk (
  .clk_i       (clk_i),
  .rst_ni      (rst_ni),
  .reg_addr_i  (reg_addr_i),
  .reg_wr_i    (reg_wr_i),
  .reg_rd_i    (reg_rd_i),
  .reg_rdata_o (reg_rdata_o),
  .reg_rvalid_o(reg_rvalid_o),
  .mem_addr_o  (mem_addr_o),
  .mem_wr_o    (mem_wr_o),
  .mem_rd_o    (mem_rd_o),
  .mem_rdata_i (mem_rdata_i)
);

// File: tb/wram_port_tb.sv
`timescale 1ns/1ps
module wram_port_tb;
  logic        clk_i = 1'b0;
  logic        rst_ni = 1'b0;
  logic [15:0] reg_addr_i = '0;
  logic        reg_wr_i = 1'b0;
  logic        reg_rd_i = 1'b0;
  logic [7:0]  reg_wdata_i = '0;
  logic [7:0]  reg_rdata_o;
  logic        reg_rvalid_o;
  logic [23:0] mem_addr_o;
  logic        mem_wr_o;
  logic        mem_rd_o;
  logic [7:0]  mem_wdata_o;
  logic [7:0]  mem_rdata_i;

  int tests = 0;
  int fails = 0;
  bit done = 1'b0;

  always #2.5 clk_i = ~clk_i;

  wram_port u_dut (
    .clk_i(clk_i), .rst_ni(rst_ni),
    .reg_addr_i(reg_addr_i), .reg_wr_i(reg_wr_i), .reg_rd_i(reg_rd_i),
    .reg_wdata_i(reg_wdata_i), .reg_rdata_o(reg_rdata_o), .reg_rvalid_o(reg_rvalid_o),
    .mem_addr_o(mem_addr_o), .mem_wr_o(mem_wr_o), .mem_rd_o(mem_rd_o),
    .mem_wdata_o(mem_wdata_o), .mem_rdata_i(mem_rdata_i)
  );

  // memory model: clocked write, same-cycle read, 1 KiB alias of low address bits
  logic [7:0] ram [1024];
  always_ff @(posedge clk_i) if (mem_wr_o) ram[mem_addr_o[9:0]] <= mem_wdata_o;
  assign mem_rdata_i = ram[mem_addr_o[9:0]];

  task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
    tests++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  // snapshot of the access cycle
  logic [23:0] s_addr;
  logic        s_wr, s_rd;
  logic [7:0]  s_wdata;

  task automatic acc(input logic [15:0] a, input logic w, input logic r, input logic [7:0] d);
    @(negedge clk_i);
    reg_addr_i = a; reg_wr_i = w; reg_rd_i = r; reg_wdata_i = d;
    #1;
    s_addr = mem_addr_o; s_wr = mem_wr_o; s_rd = mem_rd_o; s_wdata = mem_wdata_o;
    @(negedge clk_i);
    reg_wr_i = 1'b0; reg_rd_i = 1'b0; reg_addr_i = 16'h0000;
    #1;
  endtask

  function automatic logic [16:0] ptr_now();
    return mem_addr_o[16:0];
  endfunction

  typedef struct packed {
    logic [15:0] a;
    logic [7:0]  d;
    logic [16:0] p;
  } vec_t;

  // host write, expected pointer afterwards
  localparam vec_t VEC [13] = '{
    '{16'h2181, 8'hAA, 17'h000AA},  // R2
    '{16'h2182, 8'h55, 17'h055AA},  // R3
    '{16'h2183, 8'hFF, 17'h155AA},  // R4 upper data bits dropped
    '{16'h2183, 8'hFE, 17'h055AA},  // R4 bit0 clear
    '{16'h2180, 8'h11, 17'h055AB},  // R6
    '{16'h2181, 8'hFF, 17'h055FF},  // R2
    '{16'h2180, 8'h22, 17'h05600},  // R6 carry into mid byte
    '{16'h2184, 8'h33, 17'h05600},  // R9 above window
    '{16'h217F, 8'h44, 17'h05600},  // R9 below window
    '{16'h2183, 8'h01, 17'h15600},  // R4
    '{16'h2182, 8'hFF, 17'h1FF00},  // R3
    '{16'h2181, 8'hFF, 17'h1FFFF},  // R2
    '{16'h2180, 8'h5A, 17'h00000}   // R8 wrap
  };

  initial begin
    repeat (20000) @(posedge clk_i);
    if (!done) begin
      fails++;
      $display("FAIL watchdog act=timeout exp=finish");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin
    logic [16:0] prev;
    repeat (3) @(negedge clk_i);
    // R1 reset state
    chk("R1 addr in reset", 32'(mem_addr_o), 32'h7E0000);
    rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 addr", 32'(mem_addr_o), 32'h7E0000);
    chk("R1 rvalid", 32'(reg_rvalid_o), 0);
    chk("R1 rdata", 32'(reg_rdata_o), 0);
    chk("R1 strobes", 32'({mem_wr_o, mem_rd_o}), 0);

    for (int i = 0; i < 13; i++) begin
      prev = ptr_now();
      acc(VEC[i].a, 1'b1, 1'b0, VEC[i].d);
      chk($sformatf("vec%0d pointer", i), 32'(ptr_now()), 32'(VEC[i].p));
      chk("R5 bank bits", 32'(mem_addr_o[23:17]), 32'h3F);
      if (VEC[i].a == 16'h2180) begin
        chk("R6 write strobe", 32'(s_wr), 1);
        chk("R6 write data", 32'(s_wdata), 32'(VEC[i].d));
        chk("R6 pre-increment addr", 32'(s_addr), 32'h7E0000 | 32'(prev));
      end else begin
        chk("R9 no strobe on non-data write", 32'({s_wr, s_rd}), 0);
      end
    end
    chk("R8 addr after wrap", 32'(mem_addr_o), 32'h7E0000);

    // R7 write a run then read it back
    acc(16'h2183, 1'b1, 1'b0, 8'h00);
    acc(16'h2182, 1'b1, 1'b0, 8'h00);
    acc(16'h2181, 1'b1, 1'b0, 8'h10);
    for (int i = 0; i < 3; i++) acc(16'h2180, 1'b1, 1'b0, 8'hC1 + 8'(i));
    acc(16'h2181, 1'b1, 1'b0, 8'h10);
    for (int i = 0; i < 3; i++) begin
      acc(16'h2180, 1'b0, 1'b1, 8'h00);
      chk("R7 read strobe", 32'(s_rd), 1);
      chk("R7 read addr", 32'(s_addr), 32'h7E0010 + 32'(i));
      chk("R7 rvalid", 32'(reg_rvalid_o), 1);
      chk("R7 rdata", 32'(reg_rdata_o), 32'hC1 + 32'(i));
    end
    chk("R7 pointer after reads", 32'(ptr_now()), 32'h13);
    @(negedge clk_i); #1;
    chk("R7 rvalid single cycle", 32'(reg_rvalid_o), 0);

    // R9 read of a pointer register
    acc(16'h2181, 1'b0, 1'b1, 8'h00);
    chk("R9 no strobe on pointer read", 32'({s_wr, s_rd}), 0);
    chk("R9 no rvalid", 32'(reg_rvalid_o), 0);
    chk("R9 pointer kept", 32'(ptr_now()), 32'h13);

    // R10 write and read together
    acc(16'h2180, 1'b1, 1'b1, 8'h77);
    chk("R10 strobes", 32'({s_wr, s_rd}), 32'b10);
    chk("R10 no rvalid", 32'(reg_rvalid_o), 0);
    chk("R10 single increment", 32'(ptr_now()), 32'h14);

    // R8 wrap on a read
    acc(16'h2183, 1'b1, 1'b0, 8'h01);
    acc(16'h2182, 1'b1, 1'b0, 8'hFF);
    acc(16'h2181, 1'b1, 1'b0, 8'hFF);
    acc(16'h2180, 1'b0, 1'b1, 8'h00);
    chk("R8 read at top", 32'(s_addr), 32'h7FFFFF);
    chk("R8 wrap after read", 32'(mem_addr_o), 32'h7E0000);

    // R1 reset in mid run
    acc(16'h2181, 1'b1, 1'b0, 8'h9C);
    @(negedge clk_i); rst_ni = 1'b0; #1;
    chk("R1 async reset addr", 32'(mem_addr_o), 32'h7E0000);
    @(negedge clk_i); rst_ni = 1'b1;
    @(negedge clk_i); #1;
    chk("R1 addr after release", 32'(mem_addr_o), 32'h7E0000);

    done = 1'b1;
    $display("[TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule